// File: doc/BRIEF.md
# LCD Horizontal Line Timing Generator

This block produces the horizontal timing of every display line for a flat-panel LCD port. A pixel-clock enable paces it. Each line passes through four phases in a fixed order:

1. a leading wait,
2. the stretch in which pixels are sent,
3. a trailing wait,
4. a line-clock (horizontal sync) pulse.

The line then starts over. The length of every phase comes from a single 32-bit configuration word. Each field is stored as its length minus an offset.

Software writes the configuration word while the generator is stopped and then raises `run`. From then on the block repeats lines until `run` is cleared. The mode input picks between two behaviours:

- **Passive:** the pixel clock sent to the panel appears only while pixels are being output.
- **Active:** the pixel clock runs through every phase.

A pixel-valid strobe and a pixel index tell the downstream pixel path when to present each pixel and which one it is.

Top module: `lcd_hline_timer`

## Requirements
- R1: The configuration word resets to zero and reads back what was last written, except that bits 3:0 always read as zero. The fields sit at fixed positions: pixel count in bits 9:0, sync width in bits 15:10, trailing wait in bits 23:16, and leading wait in bits 31:24.
- R2: A configuration write made while `run` is 1 is ignored, and the read-back value stays unchanged.
- R3: After `run` rises, the first line starts in the leading wait. Phases then follow the order leading wait, pixels, trailing wait, sync, and back to leading wait, for every line.
- R4: The leading wait lasts (leading field + 1) pixel-enable cycles. This holds for the first line and for each line that follows a sync pulse.
- R5: A line carries (pixel field with bits 3:0 cleared) + 16 pixels. `pix_valid` is high on exactly one pixel-enable cycle per pixel, and `pix_idx` counts 0, 1, ... up to the pixel count minus 1.
- R6: The trailing wait lasts (trailing field + 1) pixel-enable cycles. It lies between the last pixel and the rise of `lclk`.
- R7: `lclk` is active high and stays high for (sync field + 1) pixel-enable cycles.
- R8: With `mode_active` = 0, `pclk_out` is held low in both waits and in the sync pulse.
- R9: With `mode_active` = 1, `pclk_out` keeps toggling through the waits and the sync pulse.
- R10: One clock after `run` is 0, `lclk`, `pix_valid` and `pclk_out` are all low.
- R11: Phase counters advance only on cycles where `pix_en` is high, so every phase length is counted in pixel-enable cycles, whatever the enable rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_en | input | 1 | Pixel-clock enable, one pulse per pixel period |
| run | input | 1 | Controller enable; lines repeat while high |
| mode_active | input | 1 | 0 = passive (gated pixel clock), 1 = active (free-running pixel clock) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read-back |
| lclk | output | 1 | Line clock (horizontal sync), active high |
| pclk_out | output | 1 | Pixel clock toward the panel |
| pix_valid | output | 1 | One pulse per pixel during the pixel phase |
| pix_idx | output | 10 | Index of the current pixel within the line |

## Verification
A table of line settings is run in turn, and the bench measures every phase length from the outputs alone.

- **Smallest settings:** all fields at zero, so every phase has its shortest length. This exposes off-by-one errors in each offset.
- **Largest settings:** the widest pixel, wait and sync values. This exposes truncated counters and overflow of the pixel limit.
- **Unaligned pixel field:** a pixel field with low bits set shows whether those bits are masked.
- **Slower enable rates:** rates of one in two and one in three separate counting in pixel-enable cycles from counting in raw clocks.
- **Both display modes:** running lines in each mode separates gating of the pixel clock from a clock that runs freely.
- **Second leading wait:** this is measured as well, to confirm the phase loop.

// File: rtl/lcd_hline_timer.sv
module lcd_hline_timer #(
  parameter int PPL_W = 10,
  parameter int HSW_W = 6,
  parameter int ELW_W = 8,
  parameter int BLW_W = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 pix_en,
  input  logic                                 run,
  input  logic                                 mode_active,
  input  logic                                 cfg_we,
  input  logic [PPL_W+HSW_W+ELW_W+BLW_W-1:0]   cfg_wdata,
  output logic [PPL_W+HSW_W+ELW_W+BLW_W-1:0]   cfg_rdata,
  output logic                                 lclk,
  output logic                                 pclk_out,
  output logic                                 pix_valid,
  output logic [PPL_W-1:0]                     pix_idx
);
  localparam int REG_W  = PPL_W + HSW_W + ELW_W + BLW_W;
  localparam int HSW_LO = PPL_W;
  localparam int ELW_LO = HSW_LO + HSW_W;
  localparam int BLW_LO = ELW_LO + ELW_W;
  localparam int M1     = (PPL_W > HSW_W) ? PPL_W : HSW_W;
  localparam int M2     = (ELW_W > BLW_W) ? ELW_W : BLW_W;
  localparam int CNT_W  = (M1 > M2) ? M1 : M2;
  localparam logic [REG_W-1:0] WMASK = {{(REG_W-4){1'b1}}, 4'b0000};

  typedef enum logic [2:0] {IDLE, LEAD, PIX, TRAIL, SYNC} phase_t;

  logic [REG_W-1:0] cfg;
  phase_t           state;
  logic [CNT_W-1:0] cnt, lim;
  logic             tog;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                cfg <= '0;
    else if (cfg_we && !run)   cfg <= cfg_wdata & WMASK;

  assign cfg_rdata = cfg;

  wire [PPL_W-1:0] f_ppl = cfg[PPL_W-1:0];
  wire [HSW_W-1:0] f_hsw = cfg[HSW_LO +: HSW_W];
  wire [ELW_W-1:0] f_elw = cfg[ELW_LO +: ELW_W];
  wire [BLW_W-1:0] f_blw = cfg[BLW_LO +: BLW_W];

  always_comb
    case (state)
      LEAD:    lim = CNT_W'(f_blw);
      PIX:     lim = CNT_W'(f_ppl) + CNT_W'(15);
      TRAIL:   lim = CNT_W'(f_elw);
      SYNC:    lim = CNT_W'(f_hsw);
      default: lim = '0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= IDLE;
      cnt   <= '0;
      tog   <= 1'b0;
    end else if (!run) begin
      state <= IDLE;
      cnt   <= '0;
      tog   <= 1'b0;
    end else if (state == IDLE) begin
      state <= LEAD;
      cnt   <= '0;
    end else if (pix_en) begin
      tog <= ~tog;
      if (cnt == lim) begin
        cnt <= '0;
        case (state)
          LEAD:    state <= PIX;
          PIX:     state <= TRAIL;
          TRAIL:   state <= SYNC;
          default: state <= LEAD;
        endcase
      end else begin
        cnt <= cnt + 1'b1;
      end
    end

  assign lclk      = (state == SYNC);
  assign pix_valid = (state == PIX) && pix_en;
  assign pix_idx   = cnt[PPL_W-1:0];
  assign pclk_out  = tog && (mode_active ? (state != IDLE) : (state == PIX));

  a_r2_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cfg_we) |=> $stable(cfg_rdata));

  a_r5_idx_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> ({1'b0, pix_idx} <= {1'b0, f_ppl} + (PPL_W+1)'(15)));

  a_r6_sync_after_trail: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lclk) |-> ($past(state) == TRAIL));

  a_r7_sync_no_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    lclk |-> !pix_valid);

  a_r8_passive_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_active && lclk) |-> !pclk_out);

  a_r10_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!lclk && !pix_valid && !pclk_out));
endmodule

// File: tb/lcd_hline_timer_test.sv
`timescale 1ns/1ps
module lcd_hline_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        mode_active = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        lclk, pclk_out, pix_valid, pix_en;
  logic [9:0]  pix_idx;
  int          div = 1;
  int          dcnt = 0;
  int          checks = 0;
  int          fails = 0;
  int          cycles = 0;

  always #4 clk = ~clk;

  always @(posedge clk) dcnt <= (dcnt >= div - 1) ? 0 : dcnt + 1;
  assign pix_en = (dcnt == 0);

  lcd_hline_timer uut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .run(run),
    .mode_active(mode_active), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .lclk(lclk), .pclk_out(pclk_out),
    .pix_valid(pix_valid), .pix_idx(pix_idx)
  );

  localparam int NV = 5;
  localparam int V_PPL [NV] = '{0, 32, 1008, 5, 48};
  localparam int V_HSW [NV] = '{0, 5, 63, 2, 1};
  localparam int V_ELW [NV] = '{0, 3, 255, 1, 10};
  localparam int V_BLW [NV] = '{0, 7, 255, 9, 0};
  localparam int V_MOD [NV] = '{0, 1, 0, 1, 0};
  localparam int V_DIV [NV] = '{1, 2, 1, 3, 2};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_vec(input int v);
    int c [5];
    int ph, bad_idx, gate_bad, togs, n_pix;
    logic prev;
    foreach (c[k]) c[k] = 0;
    ph = 0; bad_idx = 0; gate_bad = 0; togs = 0;
    n_pix = (V_PPL[v] & ~15) + 16;
    run = 1'b0;
    write_cfg({V_BLW[v][7:0], V_ELW[v][7:0], V_HSW[v][5:0], V_PPL[v][9:0]});
    mode_active = V_MOD[v][0];
    div = V_DIV[v];
    run = 1'b1;
    @(posedge clk);
    prev = pclk_out;
    for (int i = 0; i < 40000 && ph < 5; i++) begin
      @(negedge clk);
      if (pix_en) begin
        if (ph == 0 && pix_valid) ph = 1;
        else if (ph == 1 && !pix_valid) ph = 2;
        else if (ph == 2 && lclk) ph = 3;
        else if (ph == 3 && !lclk) ph = 4;
        else if (ph == 4 && pix_valid) ph = 5;
        if (ph < 5) begin
          c[ph]++;
          if (pix_valid && int'(pix_idx) != c[1] - 1) bad_idx++;
          if (ph != 1 && V_MOD[v] == 0 && pclk_out) gate_bad++;
        end
      end
      if (ph != 1 && ph < 5 && pclk_out != prev) togs++;
      prev = pclk_out;
    end
    check(c[0] == V_BLW[v] + 1, "R4 R3 first leading wait", c[0], V_BLW[v] + 1);
    check(c[1] == n_pix, "R5 R11 pixel count", c[1], n_pix);
    check(bad_idx == 0, "R5 pixel index sequence", bad_idx, 0);
    check(c[2] == V_ELW[v] + 1, "R6 trailing wait", c[2], V_ELW[v] + 1);
    check(c[3] == V_HSW[v] + 1, "R7 sync width", c[3], V_HSW[v] + 1);
    check(c[4] == V_BLW[v] + 1, "R4 R3 next-line leading wait", c[4], V_BLW[v] + 1);
    if (V_MOD[v] == 0) check(gate_bad == 0, "R8 passive clock gated", gate_bad, 0);
    else               check(togs > 0, "R9 active clock toggles", togs, 1);
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check(!lclk && !pix_valid && !pclk_out, "R10 idle after run low",
          {lclk, pix_valid, pclk_out}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cfg_rdata == 32'h0, "R1 reset value", cfg_rdata, 0);
    check(!lclk && !pix_valid && !pclk_out, "R10 reset outputs",
          {lclk, pix_valid, pclk_out}, 0);
    rst_n = 1'b1;
    write_cfg(32'hFFFF_FFFF);
    check(cfg_rdata == 32'hFFFF_FFF0, "R1 low bits read zero", cfg_rdata, 32'hFFFF_FFF0);
    write_cfg(32'h1234_5678);
    check(cfg_rdata == 32'h1234_5670, "R1 field read-back", cfg_rdata, 32'h1234_5670);
    run = 1'b1;
    write_cfg(32'h0000_0000);
    check(cfg_rdata == 32'h1234_5670, "R2 write while running ignored", cfg_rdata, 32'h1234_5670);
    run = 1'b0;
    @(negedge clk);
    for (int v = 0; v < NV; v++) run_vec(v);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule